// File: doc/BRIEF.md
# Memory Pattern Scrub Checker

This engine guards a window of byte-wide on-chip data memory against bits flipped by particle strikes. When it is enabled it first writes a known pattern into every byte of the window. It then reads the window again and again, one byte at a time, and compares each byte with the value it should hold. There is no pause between sweeps. When a byte is wrong, the engine emits an error record. That record carries the address, the byte that was read, the byte that was expected and the sweep number. The engine then writes the correct byte back and reads it once more to confirm the repair.

The engine drives a plain synchronous single-port RAM. Read data returns one cycle after the read request. Error records leave through a valid/ready stream. A record is presented with valid high and stays unchanged until ready is seen high on a clock edge. While a record waits, the engine issues no memory access. No mismatch is ever lost, and a slow consumer only slows the sweep.

Two mode pins are sampled when the engine leaves idle. The first shortens the window for smaller memories. The second splits the window into four banks that hold alternating patterns. A confirmation read that still mismatches means the bit did not take the repair. In that case the engine raises a sticky stuck flag.

Top module: `mem_scrub_engine`

## Requirements
- R1: After reset `mem_req`, `rpt_valid` and `stuck_flag` are low, and they stay so while `enable` is low.
- R2: When `enable` is high in idle, the engine writes every window address exactly once. It issues one write per cycle in ascending order from 0x20, before any read.
- R3: The window is 0x20..0xFF. It is 0x20..0x80 when `short_window` was high on leaving idle. No access falls outside the window, and memory outside it is never changed.
- R4: Without bank mode every expected byte is 0x55. With `bank_mode` high on leaving idle, the bank of an address is floor((addr-0x20)*4/L), where L is the window length (224 or 97). Even banks expect 0xAA and odd banks expect 0x55.
- R5: After the fill the engine reads the window in ascending order and wraps from the window end to 0x20 without stopping. The sweep counter is 0 during the first sweep and increments at every wrap.
- R6: Every read whose data differs from the expected byte produces exactly one record. The record holds {address, byte read, expected byte, sweep count of that read}, and its observed byte never equals its expected byte.
- R7: After a record from a normal read is accepted, the engine writes the expected byte to that address. The next read is of that same address.
- R8: While `rpt_valid` is high and `rpt_ready` is low, the record fields and valid hold steady and `mem_req` stays low.
- R9: A mismatch on the confirmation read produces its own record and sets `stuck_flag`. The engine then makes no second repair and moves on. `stuck_flag` stays high until reset.
- R10: When `enable` goes low, the engine finishes the current location and then returns to idle with no further requests. A later enable restarts with a full fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request |
| short_window | input | 1 | Reduced window end 0x80 (sampled leaving idle) |
| bank_mode | input | 1 | Alternating per-bank pattern (sampled leaving idle) |
| mem_req | output | 1 | RAM access request |
| mem_we | output | 1 | RAM write enable (read when low) |
| mem_addr | output | 8 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after a read request |
| rpt_valid | output | 1 | Error record valid |
| rpt_ready | input | 1 | Consumer accepts record |
| rpt_addr | output | 8 | Address of the faulty byte |
| rpt_observed | output | 8 | Byte read |
| rpt_expected | output | 8 | Byte expected |
| rpt_pass | output | 16 | Sweep count of the read |
| stuck_flag | output | 1 | Sticky: a repaired byte read back wrong |

## Verification
A wrong address counter or window limit shows up on `mem_addr` at the very next request. The read order breaks within one location, and the wrap breaks within one sweep of at most 224 locations. A wrong pattern or bank boundary appears as wrong `mem_wdata` during the fill, which comes before any read. Lost or duplicated records, a missed repair or a skipped confirmation read show up at the first fault injected after the fill. A wrong sweep count shows up in the `rpt_pass` field of the first record. A stall leak or an unstable record shows up in the first cycle that `rpt_ready` is held low.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FILL,
    PH_READ,
    PH_COMPARE,
    PH_REPORT,
    PH_REPAIR,
    PH_NEXT
  } scrub_phase_e;
endpackage

// File: rtl/scrub_window.sv
// Window address walker with sweep counter.
module scrub_window #(
  parameter int ADDR_W    = 8,
  parameter int PASS_W    = 16,
  parameter int WIN_START = 32,
  parameter int END_FULL  = 255,
  parameter int END_SHORT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic              count_pass,
  input  logic              short_sel,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end,
  output logic [PASS_W-1:0] pass
);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(WIN_START);
  localparam logic [ADDR_W-1:0] A_EF    = ADDR_W'(END_FULL);
  localparam logic [ADDR_W-1:0] A_ES    = ADDR_W'(END_SHORT);

  assign at_end = (addr == (short_sel ? A_ES : A_EF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= A_START;
      pass <= '0;
    end else if (restart) begin
      addr <= A_START;
      pass <= '0;
    end else if (advance) begin
      addr <= at_end ? A_START : addr + 1'b1;
      if (at_end && count_pass) pass <= pass + 1'b1;
    end
  end
endmodule

// File: rtl/scrub_pattern.sv
// Expected byte for an address, plain or banked.
module scrub_pattern #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int WIN_START = 32,
  parameter int END_FULL  = 255,
  parameter int END_SHORT = 128,
  parameter int NUM_BANKS = 4,
  parameter logic [DATA_W-1:0] PAT_BASE = 8'h55,
  parameter logic [DATA_W-1:0] PAT_ALT  = 8'hAA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              short_sel,
  input  logic              bank_sel,
  output logic [DATA_W-1:0] expected
);
  localparam int BW = $clog2(NUM_BANKS);
  localparam int SW = ADDR_W + BW + 1;
  localparam logic [SW-1:0] LEN_F = SW'(END_FULL - WIN_START + 1);
  localparam logic [SW-1:0] LEN_S = SW'(END_SHORT - WIN_START + 1);

  logic [ADDR_W-1:0] offset;
  logic [SW-1:0]     scaled;
  logic [SW-1:0]     bank;

  always_comb begin
    offset = addr - ADDR_W'(WIN_START);
    scaled = SW'(offset) * SW'(NUM_BANKS);
    bank   = scaled / (short_sel ? LEN_S : LEN_F);
    if (!bank_sel)                   expected = PAT_BASE;
    else if ((bank & SW'(1)) != '0)  expected = PAT_BASE;
    else                             expected = PAT_ALT;
  end
endmodule

// File: rtl/scrub_report.sv
// One-entry error record holder with valid/ready output.
module scrub_report #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PASS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_obs,
  input  logic [DATA_W-1:0] cap_exp,
  input  logic [PASS_W-1:0] cap_pass,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] r_addr,
  output logic [DATA_W-1:0] r_obs,
  output logic [DATA_W-1:0] r_exp,
  output logic [PASS_W-1:0] r_pass
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      r_addr <= '0;
      r_obs  <= '0;
      r_exp  <= '0;
      r_pass <= '0;
    end else if (capture) begin
      valid  <= 1'b1;
      r_addr <= cap_addr;
      r_obs  <= cap_obs;
      r_exp  <= cap_exp;
      r_pass <= cap_pass;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_scrub_engine.sv
module mem_scrub_engine #(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int PASS_W        = 16,
  parameter int WIN_START     = 32,
  parameter int WIN_END_FULL  = 255,
  parameter int WIN_END_SHORT = 128,
  parameter int NUM_BANKS     = 4,
  parameter logic [DATA_W-1:0] PAT_BASE = 8'h55,
  parameter logic [DATA_W-1:0] PAT_ALT  = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              short_window,
  input  logic              bank_mode,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rpt_valid,
  input  logic              rpt_ready,
  output logic [ADDR_W-1:0] rpt_addr,
  output logic [DATA_W-1:0] rpt_observed,
  output logic [DATA_W-1:0] rpt_expected,
  output logic [PASS_W-1:0] rpt_pass,
  output logic              stuck_flag
);
  import scrub_pkg::*;

  scrub_phase_e      phase, phase_nxt;
  logic              short_q, bank_q, verify_q, stuck_q;
  logic              restart, advance, count_pass;
  logic [ADDR_W-1:0] cur_addr;
  logic              at_end;
  logic [PASS_W-1:0] pass_cnt;
  logic [DATA_W-1:0] exp_byte;
  logic              mismatch, capture;

  scrub_window #(
    .ADDR_W(ADDR_W), .PASS_W(PASS_W), .WIN_START(WIN_START),
    .END_FULL(WIN_END_FULL), .END_SHORT(WIN_END_SHORT)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
    .count_pass(count_pass), .short_sel(short_q),
    .addr(cur_addr), .at_end(at_end), .pass(pass_cnt)
  );

  scrub_pattern #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_START(WIN_START),
    .END_FULL(WIN_END_FULL), .END_SHORT(WIN_END_SHORT),
    .NUM_BANKS(NUM_BANKS), .PAT_BASE(PAT_BASE), .PAT_ALT(PAT_ALT)
  ) u_pat (
    .addr(cur_addr), .short_sel(short_q), .bank_sel(bank_q),
    .expected(exp_byte)
  );

  scrub_report #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PASS_W(PASS_W)) u_rpt (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .cap_addr(cur_addr), .cap_obs(mem_rdata), .cap_exp(exp_byte),
    .cap_pass(pass_cnt), .ready(rpt_ready), .valid(rpt_valid),
    .r_addr(rpt_addr), .r_obs(rpt_observed), .r_exp(rpt_expected),
    .r_pass(rpt_pass)
  );

  assign mismatch = (mem_rdata != exp_byte);
  assign capture  = (phase == PH_COMPARE) && mismatch;

  // RAM master outputs
  assign mem_req    = (phase == PH_FILL) || (phase == PH_READ) || (phase == PH_REPAIR);
  assign mem_we     = (phase == PH_FILL) || (phase == PH_REPAIR);
  assign mem_addr   = cur_addr;
  assign mem_wdata  = exp_byte;
  assign stuck_flag = stuck_q;

  always_comb begin
    phase_nxt  = phase;
    restart    = 1'b0;
    advance    = 1'b0;
    count_pass = 1'b0;
    unique case (phase)
      PH_IDLE: if (enable) begin
        phase_nxt = PH_FILL;
        restart   = 1'b1;
      end
      PH_FILL: begin
        advance = 1'b1;
        if (!enable)     phase_nxt = PH_IDLE;
        else if (at_end) phase_nxt = PH_READ;
      end
      PH_READ:    phase_nxt = PH_COMPARE;
      PH_COMPARE: phase_nxt = mismatch ? PH_REPORT : PH_NEXT;
      PH_REPORT:  if (rpt_valid && rpt_ready)
                    phase_nxt = verify_q ? PH_NEXT : PH_REPAIR;
      PH_REPAIR:  phase_nxt = PH_READ;
      PH_NEXT: begin
        advance    = 1'b1;
        count_pass = 1'b1;
        phase_nxt  = enable ? PH_READ : PH_IDLE;
      end
      default:    phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      short_q  <= 1'b0;
      bank_q   <= 1'b0;
      verify_q <= 1'b0;
      stuck_q  <= 1'b0;
    end else begin
      phase <= phase_nxt;
      if (phase == PH_IDLE && enable) begin
        short_q <= short_window;
        bank_q  <= bank_mode;
      end
      if (phase == PH_REPAIR)                        verify_q <= 1'b1;
      else if (phase == PH_NEXT || phase == PH_IDLE) verify_q <= 1'b0;
      if (capture && verify_q) stuck_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scrub_checker.sv
module scrub_checker #(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int PASS_W        = 16,
  parameter int WIN_START     = 32,
  parameter int WIN_END_FULL  = 255
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rpt_valid,
  input logic              rpt_ready,
  input logic [ADDR_W-1:0] rpt_addr,
  input logic [DATA_W-1:0] rpt_observed,
  input logic [DATA_W-1:0] rpt_expected,
  input logic [PASS_W-1:0] rpt_pass,
  input logic              stuck_flag
);
  AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |-> !mem_req); // R8

  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_addr) && $stable(rpt_observed)
                                   && $stable(rpt_expected) && $stable(rpt_pass))); // R8

  AST_RECORD_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> (rpt_observed != rpt_expected)); // R6

  AST_STUCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_flag |=> stuck_flag); // R9

  AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr >= ADDR_W'(WIN_START) && mem_addr <= ADDR_W'(WIN_END_FULL))); // R3
endmodule

bind mem_scrub_engine scrub_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PASS_W(PASS_W),
  .WIN_START(WIN_START), .WIN_END_FULL(WIN_END_FULL)
) u_scrub_chk (.*);

// File: tb/tb_mem_scrub_engine.sv
`timescale 1ns/1ps
module tb_mem_scrub_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, short_window = 1'b0, bank_mode = 1'b0;
  logic mem_req, mem_we;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic rpt_valid, rpt_ready;
  logic [7:0] rpt_addr, rpt_observed, rpt_expected;
  logic [15:0] rpt_pass;
  logic stuck_flag;

  always #2.5 clk = ~clk;

  mem_scrub_engine dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .short_window(short_window),
    .bank_mode(bank_mode), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_addr(rpt_addr),
    .rpt_observed(rpt_observed), .rpt_expected(rpt_expected),
    .rpt_pass(rpt_pass), .stuck_flag(stuck_flag)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, expv, $time);
    end
  endtask

  // Behavioural RAM with optional stuck-at-0 bits on one address
  logic [7:0] mem [0:255];
  int  stuck_addr = -1;
  logic [7:0] stuck_mask = 8'h00;
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= (int'(mem_addr) == stuck_addr) ? (mem_wdata & ~stuck_mask) : mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  // Reference model state
  bit m_short, m_bank;
  bit filling = 0, rpt_pending = 0, repair_pending = 0, verify_pending = 0;
  bit last_verify = 0, m_stuck = 0;
  int fill_ptr, next_rd, pass_no, last_addr, last_pass;
  logic [7:0] last_val;
  int exp_reports = 0, seen_reports = 0;

  function automatic int win_end(bit s);
    return s ? 'h80 : 'hFF;
  endfunction

  function automatic logic [7:0] pat_of(int a, bit s, bit b);
    int len = win_end(s) - 'h20 + 1;
    if (!b) return 8'h55;
    return ((((a - 'h20) * 4) / len) % 2 == 0) ? 8'hAA : 8'h55;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we) begin
        if (filling) begin
          chk(int'(mem_addr) == fill_ptr, "R2", mem_addr, fill_ptr);
          chk(mem_wdata == pat_of(fill_ptr, m_short, m_bank), "R4", mem_wdata, pat_of(fill_ptr, m_short, m_bank));
          if (fill_ptr == win_end(m_short)) begin
            filling = 0; next_rd = 'h20; pass_no = 0;
          end else fill_ptr++;
        end else begin
          chk(repair_pending && int'(mem_addr) == last_addr, "R7", mem_addr, last_addr);
          chk(mem_wdata == pat_of(last_addr, m_short, m_bank), "R7", mem_wdata, pat_of(last_addr, m_short, m_bank));
          repair_pending = 0; verify_pending = 1;
        end
      end
      if (mem_req && !mem_we) begin
        chk(!filling && !rpt_pending && !repair_pending, "R6", {filling, rpt_pending, repair_pending}, 0);
        if (verify_pending) begin
          chk(int'(mem_addr) == last_addr, "R7", mem_addr, last_addr);
          last_verify = 1; verify_pending = 0;
        end else begin
          chk(int'(mem_addr) == next_rd, "R5", mem_addr, next_rd);
          last_verify = 0; last_pass = pass_no;
          if (next_rd == win_end(m_short)) begin next_rd = 'h20; pass_no++; end
          else next_rd++;
        end
        last_addr = mem_addr;
        last_val  = mem[mem_addr];
        if (last_val != pat_of(last_addr, m_short, m_bank)) begin
          rpt_pending = 1; exp_reports++;
        end
      end
      if (rpt_valid && !rpt_ready)
        chk(!mem_req, "R8", mem_req, 0);
      if (rpt_valid && rpt_ready) begin
        chk(rpt_pending, "R6", 0, 1);
        chk(int'(rpt_addr) == last_addr, "R6", rpt_addr, last_addr);
        chk(rpt_observed == last_val, "R6", rpt_observed, last_val);
        chk(rpt_expected == pat_of(last_addr, m_short, m_bank), "R6", rpt_expected, pat_of(last_addr, m_short, m_bank));
        chk(int'(rpt_pass) == last_pass, "R5", rpt_pass, last_pass);
        if (last_verify) m_stuck = 1;
        chk(stuck_flag == m_stuck, "R9", stuck_flag, m_stuck);
        rpt_pending = 0;
        if (!last_verify) repair_pending = 1;
        seen_reports++;
      end
    end
  end

  task automatic start_run(input bit s, input bit b);
    @(negedge clk);
    m_short = s; m_bank = b;
    short_window = s; bank_mode = b;
    filling = 1; fill_ptr = 'h20;
    rpt_pending = 0; repair_pending = 0; verify_pending = 0;
    enable = 1;
  endtask

  task automatic stop_run();
    int reqs = 0;
    @(negedge clk);
    enable = 0;
    repeat (20) @(negedge clk);
    repeat (20) begin @(negedge clk); if (mem_req) reqs++; end
    chk(reqs == 0, "R10", reqs, 0);
  endtask

  task automatic flip(input int a, input logic [7:0] m);
    @(posedge clk); #1;
    mem[a] = mem[a] ^ m;
  endtask

  task automatic wait_fill();
    while (filling) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hC3;
    rpt_ready = 1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    chk(!mem_req && !rpt_valid && !stuck_flag, "R1", {mem_req, rpt_valid, stuck_flag}, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk(!mem_req && !rpt_valid, "R1", {mem_req, rpt_valid}, 0);

    // Full window, plain pattern
    start_run(0, 0);
    wait_fill();
    for (int a = 'h20; a <= 'hFF; a++) chk(mem[a] == 8'h55, "R2", mem[a], 8'h55);
    chk(mem['h1F] == 8'hC3, "R3", mem['h1F], 8'hC3);
    repeat (800) @(negedge clk);
    flip('h40, 8'h08);
    flip('hFF, 8'h80);
    flip('h20, 8'h01);
    repeat (800) @(negedge clk);
    chk(mem['h40] == 8'h55 && mem['hFF] == 8'h55 && mem['h20] == 8'h55, "R7", mem['h40], 8'h55);

    // Back-pressure
    rpt_ready = 0;
    flip('h60, 8'h01);
    for (int k = 0; k < 1000 && !rpt_valid; k++) @(negedge clk);
    chk(rpt_valid, "R8", rpt_valid, 1);
    repeat (20) @(negedge clk);
    chk(rpt_valid && rpt_addr == 8'h60, "R8", rpt_addr, 8'h60);
    rpt_ready = 1;
    repeat (800) @(negedge clk);
    chk(mem['h60] == 8'h55, "R7", mem['h60], 8'h55);
    chk(!stuck_flag, "R9", stuck_flag, 0);
    stop_run();

    // Short window, banked pattern
    mem['h90] = 8'h3C;
    start_run(1, 1);
    wait_fill();
    for (int a = 'h20; a <= 'h80; a++)
      chk(mem[a] == pat_of(a, 1, 1), "R4", mem[a], pat_of(a, 1, 1));
    chk(mem['h38] == 8'hAA && mem['h39] == 8'h55, "R4", {mem['h38], mem['h39]}, 16'hAA55);
    flip('h50, 8'h10);
    repeat (700) @(negedge clk);
    chk(mem['h90] == 8'h3C, "R3", mem['h90], 8'h3C);

    // Stuck bit at 0x30 (bank 0, expects 0xAA)
    stuck_addr = 'h30; stuck_mask = 8'h02;
    @(posedge clk); #1; mem['h30] = mem['h30] & ~8'h02;
    repeat (700) @(negedge clk);
    chk(stuck_flag, "R9", stuck_flag, 1);
    stuck_addr = -1; stuck_mask = 8'h00;
    stop_run();
    chk(stuck_flag, "R9", stuck_flag, 1);

    // Full window, banked pattern
    start_run(0, 1);
    wait_fill();
    chk(mem['h57] == 8'hAA && mem['h58] == 8'h55 && mem['h90] == 8'hAA, "R4", mem['h58], 8'h55);
    flip('hC0, 8'hFF);
    repeat (1500) @(negedge clk);
    chk(mem['hC0] == pat_of('hC0, 0, 1), "R7", mem['hC0], pat_of('hC0, 0, 1));
    chk(exp_reports == seen_reports && !rpt_pending, "R6", seen_reports, exp_reports);
    chk(seen_reports >= 9, "R6", seen_reports, 9);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule